// File: doc/BRIEF.md
# Timed Event Stream Operator Unit

This block is one processing element of a runtime monitoring engine. It works on streams of timestamped events. Each event has a 32-bit timestamp and a 32-bit data value, and events may arrive at any time. Before reset is released, a configuration word selects one stream operator, and the unit applies that operator to its inputs. The operators are:

- lifting a scalar function over inputs held as piecewise-constant signals
- sampling one stream at the events of another
- exposing an event's timestamp as its data
- gating one stream by a boolean stream
- merging two streams with priority
- emitting a single constant event

The unit has two input streams, A and B. Each stream gives one event at a time through a valid/ready pair. A stream can also raise an end flag, which promises that it will send no more events. Only the stream or streams whose timestamp is the smallest are consumed, so the unit steps through the union of both inputs in timestamp order. For an operator with two inputs, the unit waits until both sides show either a pending event or the end flag. The result is one registered event, which appears one cycle after the step that produced it. The state kept is fixed: the latest value of each input, a flag for each input recording that it has been seen, and a done flag for the constant.

Top module: `tso_unit`

## Requirements
- R1: While reset is asserted, `out_vld` is 0, and no input is accepted while that input's valid is low.
- R2: For every operator except time, lift-NOT and const, a step happens only when both inputs are valid. If both timestamps are equal, both events are consumed together. Otherwise only the event with the smaller timestamp is consumed. A valid input whose end flag is set is never consumed. If that input is the only one not ending, the other input is consumed alone. The event a step produces appears on the outputs in the cycle after the consuming clock edge.
- R3: Lift (op 0) with function ADD (fn 0), LESS (fn 1, unsigned, 1 or 0 in bit 0) or EQUAL (fn 2) emits one event at each step timestamp, once both inputs have been seen. The result uses the latest value of each input, counting values that arrive at that same timestamp. ADD wraps modulo 2^32.
- R4: Lift with NOT (fn 3) emits one event for every A event, with data equal to bit 0 of A inverted and all other bits 0. Stream B is consumed whenever it is valid and has no effect on the output.
- R5: Lift with SELECT (fn 4) emits the latest B value when bit 0 of the latest A value is 1, and `cfg_value` otherwise. It follows the emission rule of R3.
- R6: Last (op 1) emits one event at each B event, carrying that event's timestamp and the most recent A value whose timestamp is strictly earlier. It emits nothing if there is no such A value.
- R7: Time (op 2) emits one event for every A event, with data equal to that event's timestamp. Stream B is drained and has no effect on the output.
- R8: Filter (op 3) passes an A event unchanged only when bit 0 of the latest B value is 1, where "latest" includes a B event at the same timestamp. A events before the first B event are dropped.
- R9: Merge (op 4) emits every event of both inputs in timestamp order. When the timestamps are equal, only the A event is emitted.
- R10: Const (op 5) emits exactly one event, with timestamp 0 and data `cfg_value`, in the second cycle after reset is released. It never accepts input.
- R11: Output timestamps never decrease between two resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_op | input | 3 | Operator select; held steady while reset is released |
| cfg_fn | input | 3 | Function used when the lift operator is selected |
| cfg_value | input | 32 | Constant used by const and by SELECT |
| a_vld | input | 1 | Stream A offers an event or an end flag |
| a_fin | input | 1 | Stream A has ended; its timestamp and data are ignored |
| a_ts | input | 32 | Stream A timestamp |
| a_data | input | 32 | Stream A data |
| a_rdy | output | 1 | Stream A is consumed at this edge |
| b_vld | input | 1 | Stream B offers an event or an end flag |
| b_fin | input | 1 | Stream B has ended |
| b_ts | input | 32 | Stream B timestamp |
| b_data | input | 32 | Stream B data |
| b_rdy | output | 1 | Stream B is consumed at this edge |
| out_vld | output | 1 | An output event is present |
| out_ts | output | 32 | Output event timestamp |
| out_data | output | 32 | Output event data |

## Verification
The assertions assume three things about the inputs:

- Each input stream offers strictly increasing timestamps.
- The configuration is held steady from reset onward.
- An input keeps its offer unchanged until that offer is consumed.

The ordering assertion on the output depends on these assumptions. The stimulus keeps within them: it builds each stream from sorted lists, changes a stream's head only after that stream's ready has been seen, and applies each configuration with reset asserted. Valid is dropped on some cycles on each side, so the unit is made to wait in both directions. This covers ties, lone ended streams and streams with no events.

// File: rtl/tso_pkg.sv
// Shared encodings for the timed event stream operator unit.
// Assumes: the operator and function codes are stable while out of reset.
package tso_pkg;
    typedef enum logic [2:0] {
        OP_LIFT   = 3'd0,
        OP_LAST   = 3'd1,
        OP_TIME   = 3'd2,
        OP_FILTER = 3'd3,
        OP_MERGE  = 3'd4,
        OP_CONST  = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        FN_ADD    = 3'd0,
        FN_LESS   = 3'd1,
        FN_EQUAL  = 3'd2,
        FN_NOT    = 3'd3,
        FN_SELECT = 3'd4
    } fn_e;
endpackage

// File: rtl/tso_step_arb.sv
// Step arbiter: decides which input events are consumed this cycle.
// Assumes: each stream's timestamps strictly increase; an end-flagged
// offer is never consumed; unary mode looks at A only and drains B.
module tso_step_arb #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_unary,
    input  logic            mode_idle,
    input  logic            a_vld,
    input  logic            a_fin,
    input  logic [TS_W-1:0] a_ts,
    input  logic            b_vld,
    input  logic            b_fin,
    input  logic [TS_W-1:0] b_ts,
    output logic            take_a,
    output logic            take_b
);
    logic a_ev, b_ev;

    assign a_ev = a_vld && !a_fin;
    assign b_ev = b_vld && !b_fin;

    // Pick the smaller timestamp, or both when they tie.
    always_comb begin
        take_a = 1'b0;
        take_b = 1'b0;
        if (mode_idle) begin
            take_a = 1'b0;
            take_b = 1'b0;
        end else if (mode_unary) begin
            take_a = a_ev;
            take_b = b_ev;
        end else if (a_vld && b_vld) begin
            if (a_fin && !b_fin) begin
                take_b = 1'b1;
            end else if (b_fin && !a_fin) begin
                take_a = 1'b1;
            end else if (!a_fin && !b_fin) begin
                take_a = (a_ts <= b_ts);
                take_b = (b_ts <= a_ts);
            end
        end
    end

    // R2: a two-input step consumes both only on equal timestamps
    a_r2_tie_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_unary && take_a && take_b) |-> (a_ts == b_ts));
    // R2: an end-flagged offer is never consumed
    a_r2_fin_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_vld && a_fin) |-> !take_a) and ((b_vld && b_fin) |-> !take_b));
    // R2: two-input operators advance only with both sides present
    a_r2_both_present: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_unary && !mode_idle && (take_a || take_b)) |-> (a_vld && b_vld));
    // R10: const mode never accepts input
    a_r10_idle_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        mode_idle |-> (!take_a && !take_b));
endmodule

// File: rtl/tso_op_eval.sv
// Operator evaluator: combinational result of one step, given the held
// state from before the step and the events being consumed.
// Assumes: take_a/take_b come from the step arbiter of the same cycle.
module tso_op_eval
    import tso_pkg::*;
#(
    parameter int TS_W   = 32,
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  fn_e               fn,
    input  logic [DATA_W-1:0] cfg_value,
    input  logic              take_a,
    input  logic              take_b,
    input  logic [TS_W-1:0]   a_ts,
    input  logic [DATA_W-1:0] a_data,
    input  logic [TS_W-1:0]   b_ts,
    input  logic [DATA_W-1:0] b_data,
    input  logic [DATA_W-1:0] held_a,
    input  logic [DATA_W-1:0] held_b,
    input  logic              seen_a,
    input  logic              seen_b,
    input  logic              const_done,
    output logic              emit,
    output logic [TS_W-1:0]   ev_ts,
    output logic [DATA_W-1:0] ev_data
);
    localparam logic [DATA_W-1:0] ZERO = '0;

    logic [DATA_W-1:0] nxt_a, nxt_b;
    logic              nxt_sa, nxt_sb, step;

    // Signal view of each input after this step's events are applied.
    always_comb begin
        nxt_a  = take_a ? a_data : held_a;
        nxt_b  = take_b ? b_data : held_b;
        nxt_sa = seen_a || take_a;
        nxt_sb = seen_b || take_b;
        step   = take_a || take_b;
    end

    // Per-operator emission rule and result value.
    always_comb begin
        emit    = 1'b0;
        ev_ts   = take_a ? a_ts : b_ts;
        ev_data = ZERO;
        unique case (op)
            OP_LIFT: begin
                if (fn == FN_NOT) begin
                    emit    = take_a;
                    ev_data = {{(DATA_W-1){1'b0}}, ~a_data[0]};
                end else begin
                    emit = step && nxt_sa && nxt_sb;
                    case (fn)
                        FN_ADD:    ev_data = nxt_a + nxt_b;
                        FN_LESS:   ev_data = {{(DATA_W-1){1'b0}}, (nxt_a < nxt_b)};
                        FN_EQUAL:  ev_data = {{(DATA_W-1){1'b0}}, (nxt_a == nxt_b)};
                        FN_SELECT: ev_data = nxt_a[0] ? nxt_b : cfg_value;
                        default:   emit    = 1'b0;
                    endcase
                end
            end
            OP_LAST: begin
                emit    = take_b && seen_a;
                ev_ts   = b_ts;
                ev_data = held_a;
            end
            OP_TIME: begin
                emit    = take_a;
                ev_ts   = a_ts;
                ev_data = DATA_W'(a_ts);
            end
            OP_FILTER: begin
                emit    = take_a && nxt_sb && nxt_b[0];
                ev_ts   = a_ts;
                ev_data = a_data;
            end
            OP_MERGE: begin
                emit    = step;
                ev_data = take_a ? a_data : b_data;
            end
            OP_CONST: begin
                emit    = !const_done;
                ev_ts   = '0;
                ev_data = cfg_value;
            end
            default: emit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tso_unit.sv
// Timed event stream operator unit (top). It holds the per-input latest
// value and seen flags, the const-done flag, and the registered output.
// Assumes: cfg_* are steady out of reset; per-stream timestamps strictly
// increase; an offer stays unchanged until its ready is high.
module tso_unit
    import tso_pkg::*;
#(
    parameter int TS_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_op,
    input  logic [2:0]        cfg_fn,
    input  logic [DATA_W-1:0] cfg_value,
    input  logic              a_vld,
    input  logic              a_fin,
    input  logic [TS_W-1:0]   a_ts,
    input  logic [DATA_W-1:0] a_data,
    output logic              a_rdy,
    input  logic              b_vld,
    input  logic              b_fin,
    input  logic [TS_W-1:0]   b_ts,
    input  logic [DATA_W-1:0] b_data,
    output logic              b_rdy,
    output logic              out_vld,
    output logic [TS_W-1:0]   out_ts,
    output logic [DATA_W-1:0] out_data
);
    op_e               op;
    fn_e               fn;
    logic              mode_unary, mode_idle;
    logic              take_a, take_b;
    logic [DATA_W-1:0] held_a, held_b;
    logic              seen_a, seen_b, const_done;
    logic              emit;
    logic [TS_W-1:0]   ev_ts;
    logic [DATA_W-1:0] ev_data;

    // Decode configuration into the arbiter's mode inputs.
    always_comb begin
        op         = op_e'(cfg_op);
        fn         = fn_e'(cfg_fn);
        mode_unary = (op == OP_TIME) || ((op == OP_LIFT) && (fn == FN_NOT));
        mode_idle  = (cfg_op > 3'd5) || (op == OP_CONST);
    end

    tso_step_arb #(.TS_W(TS_W)) arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_unary (mode_unary),
        .mode_idle  (mode_idle),
        .a_vld      (a_vld),
        .a_fin      (a_fin),
        .a_ts       (a_ts),
        .b_vld      (b_vld),
        .b_fin      (b_fin),
        .b_ts       (b_ts),
        .take_a     (take_a),
        .take_b     (take_b)
    );

    assign a_rdy = take_a;
    assign b_rdy = take_b;

    tso_op_eval #(.TS_W(TS_W), .DATA_W(DATA_W)) eval_i (
        .op         (op),
        .fn         (fn),
        .cfg_value  (cfg_value),
        .take_a     (take_a),
        .take_b     (take_b),
        .a_ts       (a_ts),
        .a_data     (a_data),
        .b_ts       (b_ts),
        .b_data     (b_data),
        .held_a     (held_a),
        .held_b     (held_b),
        .seen_a     (seen_a),
        .seen_b     (seen_b),
        .const_done (const_done),
        .emit       (emit),
        .ev_ts      (ev_ts),
        .ev_data    (ev_data)
    );

    // Latest value and seen flag of each input, updated on consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_a <= '0;
            held_b <= '0;
            seen_a <= 1'b0;
            seen_b <= 1'b0;
        end else begin
            if (take_a) begin
                held_a <= a_data;
                seen_a <= 1'b1;
            end
            if (take_b) begin
                held_b <= b_data;
                seen_b <= 1'b1;
            end
        end
    end

    // Const fires once; the flag sets on the first cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) const_done <= 1'b0;
        else        const_done <= 1'b1;
    end

    // Registered output event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_ts   <= '0;
            out_data <= '0;
        end else begin
            out_vld  <= emit;
            out_ts   <= ev_ts;
            out_data <= ev_data;
        end
    end

    // Checker state: timestamp of the previous output event.
    logic            have_out;
    logic [TS_W-1:0] prev_ts;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_out <= 1'b0;
            prev_ts  <= '0;
        end else if (out_vld) begin
            have_out <= 1'b1;
            prev_ts  <= out_ts;
        end
    end

    // R11: output timestamps never decrease
    a_r11_ts_order: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && have_out) |-> (out_ts >= prev_ts));
    // R3: a two-input lift result needs both inputs seen
    a_r3_lift_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && op == OP_LIFT && fn != FN_NOT) |-> (seen_a && seen_b));
    // R8: a passed event implies the control signal is true
    a_r8_filter_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && op == OP_FILTER) |-> (seen_b && held_b[0]));
    // R6: last emits only when an earlier A value existed before the step
    a_r6_last_prior: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && op == OP_LAST) |-> $past(seen_a));
    // R10: the const event carries timestamp 0 and the configured value
    a_r10_const_event: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && op == OP_CONST) |-> (out_ts == '0 && out_data == cfg_value));
    // R1: nothing is consumed from an input that is not valid
    a_r1_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_vld |-> !a_rdy) and (!b_vld |-> !b_rdy));
endmodule

// File: tb/tso_unit_tb.sv
// Bench: behavioural reference model over event lists, compared with
// the captured output sequence after each configured run.
module tso_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_op = '0, cfg_fn = '0;
    logic [31:0] cfg_value = '0;
    logic        a_vld = 1'b0, a_fin = 1'b0, b_vld = 1'b0, b_fin = 1'b0;
    logic [31:0] a_ts = '0, a_data = '0, b_ts = '0, b_data = '0;
    logic        a_rdy, b_rdy, out_vld;
    logic [31:0] out_ts, out_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    logic [63:0] src_a[$], src_b[$], exp_q[$], got_q[$];

    always #4 clk = ~clk;

    tso_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_op(cfg_op), .cfg_fn(cfg_fn),
        .cfg_value(cfg_value),
        .a_vld(a_vld), .a_fin(a_fin), .a_ts(a_ts), .a_data(a_data), .a_rdy(a_rdy),
        .b_vld(b_vld), .b_fin(b_fin), .b_ts(b_ts), .b_data(b_data), .b_rdy(b_rdy),
        .out_vld(out_vld), .out_ts(out_ts), .out_data(out_data)
    );

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got %0d cycles expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] got,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Reference model: walks both lists in timestamp order.
    task automatic model(input int op, input int fn, input logic [31:0] val);
        logic [31:0] ha, hb, r;
        bit sa, sb, ta, tb;
        int i, j;
        ha = 0; hb = 0; sa = 0; sb = 0; i = 0; j = 0;
        exp_q.delete();
        if (op == 5) begin
            exp_q.push_back({32'd0, val});
        end else if (op == 2 || (op == 0 && fn == 3)) begin
            foreach (src_a[k]) begin
                if (op == 2) exp_q.push_back({src_a[k][63:32], src_a[k][63:32]});
                else         exp_q.push_back({src_a[k][63:32], 31'd0, ~src_a[k][0]});
            end
        end else begin
            while (i < src_a.size() || j < src_b.size()) begin
                ta = (i < src_a.size());
                tb = (j < src_b.size());
                if (ta && tb) begin
                    if (src_a[i][63:32] < src_b[j][63:32]) tb = 0;
                    else if (src_b[j][63:32] < src_a[i][63:32]) ta = 0;
                end
                if (op == 1 && tb && sa) exp_q.push_back({src_b[j][63:32], ha});
                if (op == 4) exp_q.push_back(ta ? src_a[i] : src_b[j]);
                if (ta) begin ha = src_a[i][31:0]; sa = 1; end
                if (tb) begin hb = src_b[j][31:0]; sb = 1; end
                if (op == 0 && sa && sb) begin
                    case (fn)
                        0: r = ha + hb;
                        1: r = {31'd0, ha < hb};
                        2: r = {31'd0, ha == hb};
                        default: r = ha[0] ? hb : val;
                    endcase
                    exp_q.push_back({ta ? src_a[i][63:32] : src_b[j][63:32], r});
                end
                if (op == 3 && ta && sb && hb[0]) exp_q.push_back(src_a[i]);
                if (ta) i++;
                if (tb) j++;
            end
        end
    endtask

    task automatic drive(input int ia, input int ib, input int cyc);
        a_vld = (cyc % 3 != 1);
        a_fin = (ia >= src_a.size());
        {a_ts, a_data} = a_fin ? 64'd0 : src_a[ia];
        b_vld = (cyc % 4 != 2);
        b_fin = (ib >= src_b.size());
        {b_ts, b_data} = b_fin ? 64'd0 : src_b[ib];
    endtask

    task automatic run_case(input int op, input int fn, input logic [31:0] val,
                            input string tag);
        int ia, ib, idle;
        ia = 0; ib = 0; idle = 0;
        got_q.delete();
        @(negedge clk);
        rst_n = 0; cfg_op = 3'(op); cfg_fn = 3'(fn); cfg_value = val;
        a_vld = 0; b_vld = 0;
        repeat (3) @(negedge clk);
        check(out_vld == 1'b0, "R1 reset out_vld", {63'd0, out_vld}, 64'd0);
        rst_n = 1;
        drive(ia, ib, 0);
        for (int cyc = 1; cyc < 3000; cyc++) begin
            @(negedge clk);
            if (out_vld) got_q.push_back({out_ts, out_data});
            if (a_rdy) ia++;
            if (b_rdy) ib++;
            drive(ia, ib, cyc);
            if (ia >= src_a.size() && ib >= src_b.size()) idle++;
            if (idle > 8) break;
        end
        model(op, fn, val);
        check(got_q.size() == exp_q.size(), {tag, " event count"},
              64'(got_q.size()), 64'(exp_q.size()));
        foreach (exp_q[k]) begin
            if (k < got_q.size()) check(got_q[k] == exp_q[k], {tag, " event"}, got_q[k], exp_q[k]);
        end
    endtask

    function automatic logic [63:0] ev(input int t, input logic [31:0] d);
        return {32'(t), d};
    endfunction

    initial begin
        // R7 time: data equals timestamp, B drained
        src_a = '{ev(5,1), ev(9,2), ev(20,3)}; src_b = '{ev(3,7)};
        run_case(2, 0, 0, "R7 time");
        // R2 R3 lift ADD with a tie at ts 8
        src_a = '{ev(2,10), ev(8,20), ev(15,30)}; src_b = '{ev(5,1), ev(8,2), ev(30,3)};
        run_case(0, 0, 0, "R2 R3 add");
        // R3 ADD wraps modulo 2^32
        src_a = '{ev(1,32'hFFFF_FFFF)}; src_b = '{ev(1,2)};
        run_case(0, 0, 0, "R3 add wrap");
        // R3 LESS unsigned
        src_a = '{ev(1,5), ev(4,9), ev(7,32'hFFFF_FFF0)}; src_b = '{ev(1,7), ev(6,3)};
        run_case(0, 1, 0, "R3 less");
        // R3 EQUAL
        src_a = '{ev(1,4), ev(3,6)}; src_b = '{ev(2,4), ev(3,6)};
        run_case(0, 2, 0, "R3 equal");
        // R4 NOT on A only
        src_a = '{ev(1,0), ev(2,1), ev(3,2)}; src_b = '{ev(1,9)};
        run_case(0, 3, 0, "R4 not");
        // R5 SELECT
        src_a = '{ev(1,1), ev(5,0)}; src_b = '{ev(2,7), ev(6,8)};
        run_case(0, 4, 32'hAA, "R5 select");
        // R6 last, equal timestamp uses the strictly earlier value
        src_a = '{ev(2,10), ev(5,20), ev(9,30)}; src_b = '{ev(1,0), ev(5,0), ev(7,0), ev(12,0)};
        run_case(1, 0, 0, "R6 last");
        // R8 filter, control at the same timestamp counts
        src_a = '{ev(1,1), ev(3,2), ev(5,3), ev(7,5), ev(8,4)}; src_b = '{ev(3,1), ev(6,0), ev(8,1)};
        run_case(3, 0, 0, "R8 filter");
        // R9 merge with a tie at ts 4
        src_a = '{ev(1,1), ev(4,2), ev(7,3)}; src_b = '{ev(2,10), ev(4,20), ev(9,30)};
        run_case(4, 0, 0, "R9 merge");
        // R2 lift with an empty B stream produces nothing
        src_a = '{ev(1,1), ev(2,2)}; src_b = {};
        run_case(0, 0, 0, "R2 empty side");
        // R10 const single event
        src_a = '{ev(1,1)}; src_b = '{ev(1,1)};
        src_a.delete(); src_b.delete();
        run_case(5, 0, 32'h1234, "R10 const");
        // R11 long merge keeps order
        src_a.delete(); src_b.delete();
        for (int k = 0; k < 20; k++) begin
            src_a.push_back(ev(3*k, k));
            src_b.push_back(ev(2*k+1, 100+k));
        end
        run_case(4, 0, 0, "R11 order");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule